// File: doc/BRIEF.md
# Framed Serial Converter Register Front End

This block is the digital front end of a two-channel 16-bit converter. A host drives a three-wire link: an active-low frame select, a serial clock and a data line. While select is low, the block shifts one data bit on each falling serial-clock edge, most significant bit first. When select rises, the block checks that exactly 24 bits arrived. It then decodes the command fields and writes the 16-bit payload into the input register of the addressed channel or channels.

All link inputs pass through two-flop synchronisers into the system clock domain, where edges are detected. The system clock must run at least four times faster than the serial clock. The serial clock may be a gated burst or may run freely, because edges seen while select is high are ignored.

A separate active-low load input copies both input registers into the output code registers together. An active-low clear input forces the output codes to the code for 0 V. For each complete frame, the block gives exactly one of three one-cycle pulses (accepted, ignored or wrong length) and presents the decoded register-select and address fields.

Top module: `sdac_frontend`

## Requirements
- R1: Frame bits, counted from the first bit shifted in, are: bit 23 read/write (1 = read), bit 22 reserved (must be 0), bits 21:19 register select, bits 18:16 channel address and bits 15:0 data. The code registers are written only when register select is 3'b010. The decoded select and address fields appear on fr_regsel and fr_addr in the cycle of the accept or ignore pulse.
- R2: A frame starts when select falls. Bits are taken on falling edges of the serial clock only while select is low, so serial-clock edges while select is high change nothing. A gated burst clock and a free-running clock give the same result.
- R3: When select rises after exactly 24 falling serial-clock edges and the fields allow a write, the addressed input register takes the data and acc_pulse is high for one cycle.
- R4: When select rises after fewer or more than 24 falling edges, no register changes and len_err_pulse is high for one cycle.
- R5: A frame of the right length that has the read bit set, the reserved bit set, a register select other than 3'b010, or an address outside 000, 001 and 100 writes nothing, and ign_pulse is high for one cycle.
- R6: Address 3'b000 writes channel A, 3'b001 writes channel B and 3'b100 writes both channels with the same data.
- R7: While load_n is low, both output codes take their input-register values on the same clock edge. A write committed on that same edge is not seen by that load; a later load picks it up.
- R8: While clear_n is low, both output codes become the 0 V code: 16'h0000 when coding_ofs is 0 (two's complement) and 16'h8000 when coding_ofs is 1 (offset binary). Clear takes priority over load and leaves the input registers unchanged.
- R9: After reset, every input register and output code is 16'h0000 and no pulse is high.
- R10: While load_n and clear_n are both high, the output codes do not change, even when frames are written.
- R11: At most one of acc_pulse, ign_pulse and len_err_pulse is high in any cycle, and each complete frame gives exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low load of the input registers into the output codes |
| clear_n | input | 1 | Active-low clear of the output codes to the 0 V code |
| coding_ofs | input | 1 | Coding select: 0 two's complement, 1 offset binary |
| code_a | output | 16 | Output code of channel A |
| code_b | output | 16 | Output code of channel B |
| acc_pulse | output | 1 | One-cycle pulse: frame accepted and written |
| ign_pulse | output | 1 | One-cycle pulse: frame had the right length but was ignored |
| len_err_pulse | output | 1 | One-cycle pulse: frame had the wrong length |
| fr_regsel | output | 3 | Register-select field of the last complete frame |
| fr_addr | output | 3 | Address field of the last complete frame |

## Verification
A frame commit and a load strobe can land on the same clock edge. The bench provokes this by sending a frame and, in parallel, pulling load_n low for exactly the cycle in which acc_pulse is seen. The output must then show the old input-register value, and the new data must appear only after a second load. Clear and load can also fall together; with both low, the output must show the 0 V code for the selected coding.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int FRAME_BITS = 24;
  localparam int CODE_W     = 16;
  localparam int SEL_W      = 3;
  localparam int ADDR_W     = 3;
  localparam int NUM_CH     = 2;

  localparam logic [SEL_W-1:0]  REG_DATA  = 3'b010;
  localparam logic [ADDR_W-1:0] ADDR_BOTH = 3'b100;

  typedef struct packed {
    logic              rd;
    logic              rsv;
    logic [SEL_W-1:0]  regsel;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] data;
  } frame_t;

  // channel ch is a target of address a
  function automatic logic addr_hit(logic [ADDR_W-1:0] a, int ch);
    return (int'(a) == ch) || (a == ADDR_BOTH);
  endfunction

  function automatic logic addr_legal(logic [ADDR_W-1:0] a);
    return (int'(a) < NUM_CH) || (a == ADDR_BOTH);
  endfunction

  // code that stands for 0 V under the selected coding
  function automatic logic [CODE_W-1:0] zero_volt_code(logic ofs);
    return ofs ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  endfunction

  function automatic logic fields_writable(frame_t f);
    return !f.rd && !f.rsv && (f.regsel == REG_DATA) && addr_legal(f.addr);
  endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign lvl  = chain[STAGES-1];
  assign rise =  chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_lvl,
  input  logic                  sel_fall,
  input  logic                  sel_rise,
  input  logic                  sck_fall,
  input  logic                  din_lvl,
  output logic                  done,
  output logic                  len_ok,
  output logic [FRAME_BITS-1:0] word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_EXACT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_BITS + 1);

  logic                  active;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  take_bit;

  assign take_bit = active & sck_fall & ~sel_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      done   <= 1'b0;
      len_ok <= 1'b0;
      word   <= '0;
    end else begin
      done <= 1'b0;
      if (sel_fall) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (take_bit) begin
        shreg <= {shreg[FRAME_BITS-2:0], din_lvl};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
      if (sel_rise && active) begin
        active <= 1'b0;
        done   <= 1'b1;
        len_ok <= (cnt == CNT_EXACT);
        word   <= shreg;
      end
    end
  end
endmodule

// File: rtl/sdac_chan_regs.sv
module sdac_chan_regs
  import sdac_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int CW  = CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CW-1:0]          wr_data,
  input  logic                   load_n,
  input  logic                   clear_n,
  input  logic                   coding_ofs,
  output logic [NCH-1:0][CW-1:0] in_regs,
  output logic [NCH-1:0][CW-1:0] out_codes
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             in_regs[ch] <= '0;
      else if (wr_en && addr_hit(wr_addr, ch)) in_regs[ch] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       out_codes[ch] <= '0;
      else if (!clear_n) out_codes[ch] <= CW'(zero_volt_code(coding_ofs));
      else if (!load_n)  out_codes[ch] <= in_regs[ch];
    end
  end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              load_n,
  input  logic              clear_n,
  input  logic              coding_ofs,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              acc_pulse,
  output logic              ign_pulse,
  output logic              len_err_pulse,
  output logic [SEL_W-1:0]  fr_regsel,
  output logic [ADDR_W-1:0] fr_addr
);
  logic sel_lvl, sel_rise, sel_fall;
  logic sck_lvl, sck_rise, sck_fall;
  logic din_lvl, din_rise, din_fall;

  logic                      frm_done, frm_len_ok;
  logic [FRAME_BITS-1:0]     frm_word;
  frame_t                    frm;
  logic                      frm_writable;
  logic [NUM_CH-1:0][CODE_W-1:0] in_regs, out_codes;

  sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .async_in(ser_sel_n),
    .lvl(sel_lvl), .rise(sel_rise), .fall(sel_fall));

  sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .async_in(ser_clk),
    .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall));

  sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .async_in(ser_din),
    .lvl(din_lvl), .rise(din_rise), .fall(din_fall));

  sdac_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(sel_lvl), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .sck_fall(sck_fall), .din_lvl(din_lvl),
    .done(frm_done), .len_ok(frm_len_ok), .word(frm_word));

  assign frm          = frame_t'(frm_word);
  assign frm_writable = fields_writable(frm);

  assign acc_pulse     = frm_done &  frm_len_ok &  frm_writable;
  assign ign_pulse     = frm_done &  frm_len_ok & ~frm_writable;
  assign len_err_pulse = frm_done & ~frm_len_ok;
  assign fr_regsel     = frm.regsel;
  assign fr_addr       = frm.addr;

  sdac_chan_regs #(.NCH(NUM_CH), .CW(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_pulse), .wr_addr(frm.addr), .wr_data(frm.data),
    .load_n(load_n), .clear_n(clear_n), .coding_ofs(coding_ofs),
    .in_regs(in_regs), .out_codes(out_codes));

  assign code_a = out_codes[0];
  assign code_b = out_codes[1];

  // edge events of the serial clock and data are not used for state
  logic unused_edges;
  assign unused_edges = sck_lvl ^ sck_rise ^ din_rise ^ din_fall;
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_n,
  input logic          clear_n,
  input logic          coding_ofs,
  input logic          acc_pulse,
  input logic          ign_pulse,
  input logic          len_err_pulse,
  input logic          frm_done,
  input logic          frm_len_ok,
  input logic [CW-1:0] in_a,
  input logic [CW-1:0] in_b,
  input logic [CW-1:0] code_a,
  input logic [CW-1:0] code_b,
  input logic          unused_edges
);
  logic unused_chk;
  assign unused_chk = unused_edges;

  a_r3_accept_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |=> !acc_pulse);

  a_r4_bad_length_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !frm_len_ok) |=> ($stable(in_a) && $stable(in_b)));

  a_r5_ignored_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ign_pulse |=> ($stable(in_a) && $stable(in_b)));

  a_r7_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |=> (code_a == $past(in_a) && code_b == $past(in_b)));

  a_r8_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (code_a == ($past(coding_ofs) ? {1'b1, {(CW-1){1'b0}}} : {CW{1'b0}})
                  && code_a == code_b));

  a_r9_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (code_a == '0 && code_b == '0 && in_a == '0 && in_b == '0));

  a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && clear_n) |=> ($stable(code_a) && $stable(code_b)));

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_pulse, ign_pulse, len_err_pulse}));
endmodule

bind sdac_frontend sdac_frontend_chk #(.CW(sdac_pkg::CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .clear_n(clear_n),
  .coding_ofs(coding_ofs), .acc_pulse(acc_pulse), .ign_pulse(ign_pulse),
  .len_err_pulse(len_err_pulse), .frm_done(frm_done), .frm_len_ok(frm_len_ok),
  .in_a(in_regs[0]), .in_b(in_regs[1]), .code_a(code_a), .code_b(code_b),
  .unused_edges(unused_edges));

// File: tb/sim_sdac_frontend.sv
module sim_sdac_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
  logic load_n = 1'b1, clear_n = 1'b1, coding_ofs = 1'b0;
  logic [15:0] code_a, code_b;
  logic acc_pulse, ign_pulse, len_err_pulse;
  logic [2:0] fr_regsel, fr_addr;

  int n_chk = 0, n_fail = 0;
  int acc_cnt = 0, ign_cnt = 0, len_cnt = 0;
  logic [2:0] last_sel = '0, last_addr = '0;
  logic [15:0] mod_a = '0, mod_b = '0;

  always #5 clk = ~clk;

  sdac_frontend u0 (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .load_n(load_n), .clear_n(clear_n),
    .coding_ofs(coding_ofs), .code_a(code_a), .code_b(code_b),
    .acc_pulse(acc_pulse), .ign_pulse(ign_pulse),
    .len_err_pulse(len_err_pulse), .fr_regsel(fr_regsel), .fr_addr(fr_addr));

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_pulse) acc_cnt++;
      if (ign_pulse) ign_cnt++;
      if (len_err_pulse) len_cnt++;
      if (acc_pulse || ign_pulse) begin
        last_sel  = fr_regsel;
        last_addr = fr_addr;
      end
    end
  end

  // {class, bit count, word}; class 0 accept, 1 ignore, 2 wrong length
  localparam logic [31:0] VEC [0:11] = '{
    {2'd0, 6'd24, 24'h101234},
    {2'd0, 6'd24, 24'h11ABCD},
    {2'd2, 6'd23, 24'h105555},
    {2'd2, 6'd25, 24'h110F0F},
    {2'd1, 6'd24, 24'h907777},
    {2'd1, 6'd24, 24'h506666},
    {2'd1, 6'd24, 24'h122222},
    {2'd1, 6'd24, 24'h083333},
    {2'd0, 6'd24, 24'h148001},
    {2'd0, 6'd24, 24'h10FFFF},
    {2'd2, 6'd1,  24'h000001},
    {2'd1, 6'd24, 24'h154444}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sck_pulse();
    #40 ser_clk = 1'b0;
    #40 ser_clk = 1'b1;
  endtask

  task automatic send_frame(input logic [31:0] w, input int nbits, input bit freerun);
    @(negedge clk);
    if (freerun) begin ser_din = 1'b1; repeat (3) sck_pulse(); end
    #20 ser_sel_n = 1'b0;
    #20;
    for (int k = nbits - 1; k >= 0; k--) begin
      ser_din = w[k];
      sck_pulse();
    end
    #40 ser_sel_n = 1'b1;
    if (freerun) begin ser_din = 1'b1; repeat (3) sck_pulse(); end
    repeat (8) @(negedge clk);
  endtask

  task automatic load_once();
    @(negedge clk) load_n = 1'b0;
    @(negedge clk) load_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 code_a after reset", 32'(code_a), 32'h0);
    chk("R9 code_b after reset", 32'(code_b), 32'h0);
    chk("R9 pulses after reset", 32'({acc_pulse, ign_pulse, len_err_pulse}), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    foreach (VEC[i]) begin
      logic [1:0]  cls;
      logic [5:0]  nb;
      logic [23:0] wd;
      logic [31:0] sent;
      int a0, i0, l0;
      bit fr;
      cls = VEC[i][31:30];
      nb  = VEC[i][29:24];
      wd  = VEC[i][23:0];
      fr  = (i % 2) == 1;
      sent = (nb > 24) ? (32'(wd) << (nb - 24)) : 32'(wd);
      a0 = acc_cnt; i0 = ign_cnt; l0 = len_cnt;
      send_frame(sent, int'(nb), fr);
      chk("R11 one outcome per frame", 32'((acc_cnt - a0) + (ign_cnt - i0) + (len_cnt - l0)), 32'd1);
      case (cls)
        2'd0: begin
          chk(fr ? "R2 accept with free-running clock" : "R3 accept", 32'(acc_cnt - a0), 32'd1);
          chk("R1 regsel field", 32'(last_sel), 32'(wd[21:19]));
          chk("R1 addr field", 32'(last_addr), 32'(wd[18:16]));
          if (wd[18:16] == 3'b000 || wd[18:16] == 3'b100) mod_a = wd[15:0];
          if (wd[18:16] == 3'b001 || wd[18:16] == 3'b100) mod_b = wd[15:0];
        end
        2'd1: begin
          chk("R5 ignore pulse", 32'(ign_cnt - i0), 32'd1);
          chk("R1 addr field on ignore", 32'(last_addr), 32'(wd[18:16]));
        end
        default: chk("R4 length error pulse", 32'(len_cnt - l0), 32'd1);
      endcase
      load_once();
      chk("R6 channel A after load", 32'(code_a), 32'(mod_a));
      chk("R6 channel B after load", 32'(code_b), 32'(mod_b));
    end

    // R10: a write without load leaves outputs alone
    send_frame(32'h14_1111, 24, 1'b0);
    chk("R10 code_a held", 32'(code_a), 32'(mod_a));
    chk("R10 code_b held", 32'(code_b), 32'(mod_b));
    mod_a = 16'h1111; mod_b = 16'h1111;
    load_once();
    chk("R7 load both A", 32'(code_a), 32'h1111);
    chk("R7 load both B", 32'(code_b), 32'h1111);

    // R8: clear in both codings, clear over load, inputs kept
    @(negedge clk) clear_n = 1'b0;
    @(negedge clk) clear_n = 1'b1;
    chk("R8 clear two's complement", 32'(code_a), 32'h0000);
    coding_ofs = 1'b1;
    @(negedge clk) begin clear_n = 1'b0; load_n = 1'b0; end
    @(negedge clk) begin clear_n = 1'b1; load_n = 1'b1; end
    chk("R8 clear offset binary beats load A", 32'(code_a), 32'h8000);
    chk("R8 clear offset binary B", 32'(code_b), 32'h8000);
    load_once();
    chk("R8 input register kept through clear", 32'(code_a), 32'h1111);
    coding_ofs = 1'b0;

    // R7: commit and load on the same edge
    fork
      send_frame(32'h10_4242, 24, 1'b0);
      begin
        do @(negedge clk); while (!acc_pulse);
        load_n = 1'b0;
        @(negedge clk) load_n = 1'b1;
        chk("R7 same-edge load sees old value", 32'(code_a), 32'h1111);
      end
    join
    load_once();
    chk("R7 later load sees new value", 32'(code_a), 32'h4242);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule